// File: doc/BRIEF.md
# Two-Wire Serial Slave with Auto-Incrementing Word Pointer

This block lets a two-wire serial bus master (I2C-style, open-drain SDA and SCL) read and write a small byte-addressed register or RAM space. The system clock samples both bus lines through two flip-flops. The block finds START, repeated START and STOP conditions and compares the first byte of each transfer with a fixed 7-bit device address. On a write, the first byte after the address goes into a word pointer, and every later byte is written to memory at that pointer. On a read, the block sends memory bytes from the pointer, one after another, for as long as the master acknowledges them.

The pointer is the only state that lasts from one transfer to the next. A write advances it after the acknowledge clock of each data byte. A read advances it only when the master acknowledges a byte. A read with no pointer write in front of it therefore starts where the last transfer left off. The memory sits outside the block. Its read port must be combinational, and its write port is a single-cycle strobe at the pointer address. The block never drives SCL, so it cannot stretch the clock.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A START followed by the byte {1101000, R/W}, with R/W in bit 0 and bits sent MSB first, is acknowledged: the block drives SDA low during the 9th SCL clock.
- R2: After an address byte that does not match, the block sends no ACK, keeps SDA released and ignores every later byte until the next START. The pointer and the memory stay unchanged.
- R3: In a write transfer (R/W=0), the first byte after the address is loaded into the word pointer and acknowledged.
- R4: Each data byte after the pointer byte is written to memory at the pointer with a one-cycle write strobe and acknowledged. The pointer then increments at the end of that byte's acknowledge clock.
- R5: A pointer write, then a repeated START and the address with R/W=1, makes the block send the byte stored at the new pointer.
- R6: During a read, a master ACK (SDA low in the 9th clock) increments the pointer, and the block then sends the byte at the next address. This continues until STOP.
- R7: A master NACK on a read byte leaves the pointer unchanged and releases SDA. The block then sends nothing until the next START.
- R8: A read that begins without a pointer write starts at the address the pointer currently holds.
- R9: The pointer wraps from 2^AW-1 to 0, both for writes and for reads.
- R10: A STOP releases SDA and returns the block to idle. A START or repeated START at any point restarts the address phase.
- R11: After reset, SDA is released, no write strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Drive SDA low when 1; release the line when 0 |
| mem_addr | output | AW | Memory address (the word pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_rdata | input | 8 | Combinational read data at mem_addr |

## Verification
The bench drives pointer writes across the top of the address space and reads them back. A pointer without wrap logic, or one that advances before the write, would put bytes at the wrong locations. It ends read bursts with a NACK and then does a current-address read. A block that advanced on the NACK would return the following byte, and one that kept driving SDA would corrupt the STOP. It also sends a wrong device address followed by extra bytes. A block that acknowledged those bytes, or loaded them as a pointer, would show up in the ACK bits or in the next current-address read. Randomly sized bursts with random data and addresses check that the pointer carries over correctly between transfers.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK_W, S_AACK_R, S_PTR, S_PACK,
    S_WDATA, S_DACK, S_TX, S_MACK
  } st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    sreg, sh;
  logic [3:0]    cnt;
  logic [AW-1:0] ptr;
  logic          mack;

  wire scl      = scl_q[1];
  wire sda      = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  assign mem_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sreg      <= '0;
      sh        <= '0;
      cnt       <= '0;
      ptr       <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_PTR, S_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              sreg <= {sreg[6:0], sda};
              cnt  <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= sreg[0] ? S_AACK_R : S_AACK_W;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_PTR) begin
                sda_oe <= 1'b1;
                ptr    <= AW'(sreg);
                st     <= S_PACK;
              end else begin
                sda_oe    <= 1'b1;
                mem_we    <= 1'b1;
                mem_wdata <= sreg;
                st        <= S_DACK;
              end
            end
          end
          S_AACK_W: if (scl_fall) begin sda_oe <= 1'b0; st <= S_PTR; end
          S_PACK:   if (scl_fall) begin sda_oe <= 1'b0; st <= S_WDATA; end
          S_DACK:   if (scl_fall) begin sda_oe <= 1'b0; ptr <= ptr + 1'b1; st <= S_WDATA; end
          S_AACK_R: if (scl_fall) begin
            sh     <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
            cnt    <= 4'd1;
            st     <= S_TX;
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda;
              if (!sda) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                cnt    <= 4'd1;
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> (ptr == $past(ptr) + 1'b1) || ($past(st) == S_PTR));

  // R1
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R11
  idle_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> !sda_oe || !scl);

endmodule

// File: tb/tb_i2c_ptr_slave.sv
module tb_i2c_ptr_slave;
  localparam int AW = 8;
  localparam logic [6:0] DEV = 7'b1101000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem     [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] exp_ptr;
  int checks = 0, errors = 0;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  i2c_ptr_slave #(.DEV_ADDR(DEV), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q; repeat (8) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1; scl_m = 1; q; sda_m = 0; q; scl_m = 0; q; endtask
  task automatic i2c_rstart; sda_m = 1; q; scl_m = 1; q; sda_m = 0; q; scl_m = 0; q; endtask
  task automatic i2c_stop; sda_m = 0; q; scl_m = 1; q; sda_m = 1; q; endtask

  task automatic wbit(input bit b);
    sda_m = b; q; scl_m = 1; q; q; scl_m = 0; q;
  endtask

  task automatic rbit(output bit b);
    sda_m = 1; q; scl_m = 1; q; b = sda_line; q; scl_m = 0; q;
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input bit ack, output logic [7:0] d);
    bit b;
    for (int i = 0; i < 8; i++) begin rbit(b); d = {d[6:0], b}; end
    wbit(~ack);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start;
    wbyte({DEV, 1'b0}, ack); chk(ack, "R1", ack, 1);
    wbyte(a, ack);           chk(ack, "R3", ack, 1);
    exp_ptr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack); chk(ack, req, ack, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr++;
    end
    i2c_stop;
    chk(sda_oe == 0, "R10", sda_oe, 0);
  endtask

  task automatic do_read(input bit rnd, input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start;
    if (rnd) begin
      wbyte({DEV, 1'b0}, ack); chk(ack, "R1", ack, 1);
      wbyte(a, ack);           chk(ack, "R3", ack, 1);
      exp_ptr = a;
      i2c_rstart;
    end
    wbyte({DEV, 1'b1}, ack); chk(ack, "R1", ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      if (i != n - 1) exp_ptr++;
    end
    chk(sda_oe == 0, "R7", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    exp_ptr = 0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 0, "R11", sda_oe, 0);
    chk(mem_we == 0, "R11", mem_we, 0);
    rst_n = 1; q;
    // R11 pointer is 0; R8 current-address read
    do_read(0, 0, 2, "R8");
    // R3 R4 write burst, R5 random read, R6 sequential
    do_write(8'h30, 4, "R4");
    do_read(1, 8'h30, 4, "R5");
    // R8 resume: pointer sits on the last NACKed byte 0x33
    do_read(0, 0, 3, "R8");
    // R4 pointer after write burst
    do_write(8'h50, 2, "R4");
    do_read(0, 0, 1, "R4");
    // R9 wrap for write and read
    do_write(8'hFE, 4, "R9");
    do_read(1, 8'hFE, 4, "R9");
    // R7 NACK does not advance
    do_read(1, 8'h20, 3, "R6");
    do_read(0, 0, 1, "R7");
    // R2 wrong address then extra bytes ignored
    i2c_start;
    wbyte({7'b1101001, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    wbyte(8'h10, ack);              chk(!ack, "R2", ack, 0);
    wbyte(8'hEE, ack);              chk(!ack, "R2", ack, 0);
    i2c_stop;
    do_read(0, 0, 1, "R2");
    chk(mem[8'h10] == exp_mem[8'h10], "R2", mem[8'h10], exp_mem[8'h10]);
    // R10 repeated START restarts the address phase mid-write
    i2c_start;
    wbyte({DEV, 1'b0}, ack); chk(ack, "R10", ack, 1);
    wbyte(8'h40, ack);       chk(ack, "R3", ack, 1);
    i2c_rstart;
    wbyte({DEV, 1'b0}, ack); chk(ack, "R10", ack, 1);
    wbyte(8'h60, ack);       chk(ack, "R10", ack, 1);
    d = 8'h5C;
    wbyte(d, ack);           chk(ack, "R4", ack, 1);
    exp_mem[8'h60] = d; exp_ptr = 8'h61;
    i2c_stop;
    do_read(1, 8'h60, 1, "R10");
    chk(mem[8'h40] == exp_mem[8'h40], "R10", mem[8'h40], exp_mem[8'h40]);
    // random bursts
    for (int it = 0; it < 12; it++) begin
      logic [7:0] a;
      a = 8'($urandom);
      do_write(a, 1 + int'($urandom % 4), "R4");
      if ($urandom % 2) do_read(0, 0, 1 + int'($urandom % 3), "R8");
      else              do_read(1, 8'($urandom), 1 + int'($urandom % 4), "R6");
    end
    finish_run;
  end
endmodule